// File: doc/BRIEF.md
# Lost-Locality Warp Throttling Scheduler

This block picks one warp per cycle for a GPU core. Before the pick, it narrows the field to the warps that are losing the most cache locality. The memory side reports a victim-tag hit whenever a warp misses in L1 and the missing tag is found in that warp's own victim store. The block turns each warp's hit count into a lost-locality score: the hit total times a throttle constant times a cumulative cutoff, divided by the number of instructions the warp has issued. A shared sequential divider computes this score. Every score then drains by one per cycle, down to a floor equal to the base locality score.

A ranking engine runs one pass after another. Each pass takes a snapshot of the scores and then, one step per cycle, takes the highest unranked score. Warps are admitted while the running total stays within the cutoff, which is the number of active warps times the base score. The new admitted mask replaces the old one only when the pass ends. Round-robin selection then runs over the warps that are ready, admitted and active.

Top module: `warp_throttle_sched`

## Requirements
- R1: While reset is held, and until the first ranking pass commits, every bit of `allow_mask` is 1. The round-robin pointer starts so that warp 0 is the first candidate.
- R2: The selected warp is the first eligible warp after the previously selected warp, in ascending index order with wrap-around. The pointer moves only on cycles when a warp is selected.
- R3: A warp is eligible when bit i of `ready`, `allow_mask` and `active` are all 1. `sel_valid` is 1 exactly when some warp is eligible, and `sel_warp` is the binary index of the chosen warp.
- R4: When a victim hit is counted, the warp's score is reloaded with hits × `cfg_k` × cutoff ÷ issued count, with the quotient truncated. An issued count of zero counts as 1. Results above the score range saturate, and a result below the floor is raised to the floor.
- R5: The cutoff is the number of set bits in `active` times `cfg_base`.
- R6: Each cycle, every score above `cfg_base` drops by 1 and every other score is set to `cfg_base`. With no recent hits, every active warp is admitted.
- R7: A ranking pass orders active warps by descending score, with ties going to the lower index. It admits them in that order while the running sum of their scores is no more than the cutoff, and it stops admitting at the first warp that would exceed it.
- R8: The top-ranked active warp is always admitted, even when its score alone exceeds the cutoff.
- R9: `allow_mask` changes only when a ranking pass completes. A warp whose `active` bit was 0 when the pass started is never admitted by that pass.
- R10: A pulse on `vhit_valid` adds one hit only to the warp whose index is on `vhit_warp`. A pulse on bit i of `issued` adds one instruction only to warp i. Both counters saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| active | input | NW | Bit i set: warp i is resident on the core |
| ready | input | NW | Bit i set: warp i has an instruction ready to issue |
| vhit_valid | input | 1 | One-cycle strobe: L1 miss found in the warp's own victim store |
| vhit_warp | input | log2(NW) | Warp index for the victim hit |
| issued | input | NW | Bit i pulses once per instruction issued by warp i |
| cfg_k | input | KW | Throttle constant |
| cfg_base | input | BW | Base locality score, also the score floor |
| allow_mask | output | NW | Admitted warp set from the last completed pass |
| sel_valid | output | 1 | A warp is selected this cycle |
| sel_warp | output | log2(NW) | Index of the selected warp |

## Verification
The assertions assume that `vhit_warp` names a real warp whenever `vhit_valid` is high. They also assume that `ready` and `active` are held steady between clock edges, because the selection is combinational from those inputs. The stimulus draws random ready patterns and sends victim hits only at warp indices below NW. It spaces those hits far enough apart that each division finishes and the scores settle before the admitted mask is sampled. The round-robin checks always begin by presenting only warp 0 as ready, which puts the pointer in a known state before random patterns are applied.

// File: rtl/warp_throttle_sched.sv
module warp_throttle_sched #(
  parameter int NW = 8,
  parameter int CW = 8,
  parameter int KW = 8,
  parameter int BW = 8,
  parameter int SW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NW-1:0]           active,
  input  logic [NW-1:0]           ready,
  input  logic                    vhit_valid,
  input  logic [$clog2(NW)-1:0]   vhit_warp,
  input  logic [NW-1:0]           issued,
  input  logic [KW-1:0]           cfg_k,
  input  logic [BW-1:0]           cfg_base,
  output logic [NW-1:0]           allow_mask,
  output logic                    sel_valid,
  output logic [$clog2(NW)-1:0]   sel_warp
);
  localparam int IW   = $clog2(NW);
  localparam int AW   = $clog2(NW + 1);
  localparam int CUTW = BW + AW;
  localparam int NUMW = CW + KW + CUTW;
  localparam int SUMW = SW + IW + 1;
  localparam int DCW  = $clog2(NUMW);
  localparam int RKW  = $clog2(NW + 2);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [SW-1:0] SMAX = '1;

  logic [CW-1:0]   hits  [NW];
  logic [CW-1:0]   instr [NW];
  logic [SW-1:0]   score [NW];
  logic [NW-1:0]   pend;

  logic [AW-1:0]   n_act;
  logic [CUTW-1:0] cutoff;
  always_comb begin
    n_act = '0;
    for (int i = 0; i < NW; i++) n_act += AW'(active[i]);
  end
  assign cutoff = CUTW'(n_act) * CUTW'(cfg_base);

  // shared sequential divider
  logic            busy;
  logic [DCW-1:0]  dcnt;
  logic [IW-1:0]   dwarp;
  logic [NUMW-1:0] dnum, dquo;
  logic [CW-1:0]   drem, dden;
  logic            pick_ok;
  logic [IW-1:0]   pick;
  always_comb begin
    pick_ok = 1'b0;
    pick    = '0;
    for (int i = NW - 1; i >= 0; i--)
      if (pend[i]) begin pick_ok = 1'b1; pick = IW'(i); end
  end
  wire start = !busy && pick_ok;

  wire [CW:0]      rem_sh = {drem, dnum[NUMW-1]};
  wire             rem_ge = rem_sh >= {1'b0, dden};
  wire [CW:0]      rem_nx = rem_ge ? rem_sh - {1'b0, dden} : rem_sh;
  wire [NUMW-1:0]  quo_nx = {dquo[NUMW-2:0], rem_ge};
  wire             div_wr = busy && (dcnt == DCW'(NUMW - 1));
  wire [SW-1:0]    q_sat  = (|quo_nx[NUMW-1:SW]) ? SMAX : quo_nx[SW-1:0];
  wire [SW-1:0]    q_fl   = (q_sat > SW'(cfg_base)) ? q_sat : SW'(cfg_base);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; dcnt <= '0; dwarp <= '0;
      dnum <= '0; dquo <= '0; drem <= '0; dden <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      dcnt  <= '0;
      dwarp <= pick;
      dnum  <= NUMW'(hits[pick]) * NUMW'(cfg_k) * NUMW'(cutoff);
      dden  <= (instr[pick] == '0) ? CW'(1) : instr[pick];
      dquo  <= '0;
      drem  <= '0;
    end else if (busy) begin
      dnum <= {dnum[NUMW-2:0], 1'b0};
      dquo <= quo_nx;
      drem <= rem_nx[CW-1:0];
      dcnt <= dcnt + 1'b1;
      if (div_wr) busy <= 1'b0;
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_warp
    wire hit_g = vhit_valid && (vhit_warp == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hits[g] <= '0; instr[g] <= '0; score[g] <= '0; pend[g] <= 1'b0;
      end else begin
        if (hit_g && hits[g] != CMAX) hits[g] <= hits[g] + 1'b1;
        if (issued[g] && instr[g] != CMAX) instr[g] <= instr[g] + 1'b1;
        if (hit_g) pend[g] <= 1'b1;
        else if (start && pick == IW'(g)) pend[g] <= 1'b0;
        if (div_wr && dwarp == IW'(g)) score[g] <= q_fl;
        else if (score[g] > SW'(cfg_base)) score[g] <= score[g] - 1'b1;
        else score[g] <= SW'(cfg_base);
      end
    end
  end

  // iterative ranking pass
  logic [RKW-1:0]  rk_step;
  logic [SW-1:0]   snap [NW];
  logic [NW-1:0]   snap_act, taken, rk_newm;
  logic [CUTW-1:0] rk_cut;
  logic [SUMW-1:0] rk_sum;
  logic            rk_stop, rk_first;
  logic            mx_ok;
  logic [IW-1:0]   mx_idx;
  logic [SW-1:0]   mx_val;
  always_comb begin
    mx_ok = 1'b0; mx_idx = '0; mx_val = '0;
    for (int i = 0; i < NW; i++)
      if (!taken[i] && (!mx_ok || snap[i] > mx_val)) begin
        mx_ok = 1'b1; mx_idx = IW'(i); mx_val = snap[i];
      end
  end
  wire [SUMW-1:0] sum_nx    = rk_sum + SUMW'(mx_val);
  wire            rk_commit = (rk_step == RKW'(NW + 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rk_step <= '0; snap_act <= '0; taken <= '0; rk_newm <= '0;
      rk_cut <= '0; rk_sum <= '0; rk_stop <= 1'b0; rk_first <= 1'b1;
      allow_mask <= '1;
      for (int i = 0; i < NW; i++) snap[i] <= '0;
    end else if (rk_step == '0) begin
      for (int i = 0; i < NW; i++) snap[i] <= score[i];
      snap_act <= active;
      taken    <= ~active;
      rk_cut   <= cutoff;
      rk_sum   <= '0;
      rk_stop  <= 1'b0;
      rk_first <= 1'b1;
      rk_newm  <= '0;
      rk_step  <= rk_step + 1'b1;
    end else if (rk_commit) begin
      allow_mask <= rk_newm;
      rk_step    <= '0;
    end else begin
      if (mx_ok) begin
        taken[mx_idx] <= 1'b1;
        if (!rk_stop && (rk_first || sum_nx <= SUMW'(rk_cut))) begin
          rk_newm[mx_idx] <= 1'b1;
          rk_sum          <= sum_nx;
        end else begin
          rk_stop <= 1'b1;
        end
        rk_first <= 1'b0;
      end
      rk_step <= rk_step + 1'b1;
    end
  end

  // round-robin over eligible warps
  logic [IW-1:0] rr_ptr;
  wire  [NW-1:0] elig = ready & allow_mask & active;
  always_comb begin
    sel_valid = 1'b0;
    sel_warp  = '0;
    for (int k = NW; k >= 1; k--)
      if (elig[(int'(rr_ptr) + k) % NW]) begin
        sel_valid = 1'b1;
        sel_warp  = IW'((int'(rr_ptr) + k) % NW);
      end
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_ptr <= IW'(NW - 1);
    else if (sel_valid) rr_ptr <= sel_warp;
  end
endmodule

// File: rtl/warp_throttle_sched_chk.sv
module warp_throttle_sched_chk #(
  parameter int NW   = 8,
  parameter int IW   = 3,
  parameter int DCW  = 5,
  parameter int NUMW = 28
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NW-1:0]  active,
  input logic [NW-1:0]  ready,
  input logic [NW-1:0]  allow_mask,
  input logic           sel_valid,
  input logic [IW-1:0]  sel_warp,
  input logic           rk_commit,
  input logic [NW-1:0]  snap_act,
  input logic [NW-1:0]  rk_newm,
  input logic           busy,
  input logic [DCW-1:0] dcnt
);
  wire [NW-1:0] elig = ready & allow_mask & active;

  assert_sel_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (ready[sel_warp] && allow_mask[sel_warp] && active[sel_warp]));

  assert_sel_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|elig) |-> sel_valid);

  assert_rr_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sel_valid) && sel_valid && $countones(elig) > 1)
      |-> sel_warp != $past(sel_warp));

  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rk_commit |=> $stable(allow_mask));

  assert_no_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rk_commit |-> (rk_newm & ~snap_act) == '0);

  assert_top_admit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_commit && (|snap_act)) |-> (|rk_newm));

  assert_div_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> dcnt < DCW'(NUMW));
endmodule

bind warp_throttle_sched warp_throttle_sched_chk #(
  .NW(NW), .IW(IW), .DCW(DCW), .NUMW(NUMW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .ready(ready),
  .allow_mask(allow_mask), .sel_valid(sel_valid), .sel_warp(sel_warp),
  .rk_commit(rk_commit), .snap_act(snap_act), .rk_newm(rk_newm),
  .busy(busy), .dcnt(dcnt)
);

// File: tb/warp_throttle_sched_bench.sv
`timescale 1ns/1ps
module warp_throttle_sched_bench;
  localparam int NW = 8;
  logic clk = 0, rst_n = 0;
  logic [NW-1:0] active = '1, ready = '0, issued = '0;
  logic vhit_valid = 0;
  logic [2:0] vhit_warp = '0;
  logic [7:0] cfg_k = 8'd16, cfg_base = 8'd4;
  logic [NW-1:0] allow_mask;
  logic sel_valid;
  logic [2:0] sel_warp;
  int total = 0, bad = 0, last = NW - 1;
  bit done = 0;

  always #4 clk = ~clk;

  warp_throttle_sched u_warp_throttle_sched (
    .clk(clk), .rst_n(rst_n), .active(active), .ready(ready),
    .vhit_valid(vhit_valid), .vhit_warp(vhit_warp), .issued(issued),
    .cfg_k(cfg_k), .cfg_base(cfg_base), .allow_mask(allow_mask),
    .sel_valid(sel_valid), .sel_warp(sel_warp));

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int rr_next(int prev, logic [NW-1:0] el);
    for (int k = 1; k <= NW; k++)
      if (el[(prev + k) % NW]) return (prev + k) % NW;
    return -1;
  endfunction

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hit(int w);
    @(negedge clk); vhit_valid = 1; vhit_warp = 3'(w);
    @(negedge clk); vhit_valid = 0;
  endtask

  task automatic issue(int w, int n);
    repeat (n) begin @(negedge clk); issued = NW'(1) << w; end
    @(negedge clk); issued = '0;
  endtask

  task automatic rr_run(int n, logic [NW-1:0] amask, string req);
    @(negedge clk); ready = NW'(1);
    @(negedge clk); last = 0;
    for (int i = 0; i < n; i++) begin
      int exp;
      ready = NW'($urandom);
      #1;
      exp = rr_next(last, ready & amask);
      chk({req, " valid"}, int'(sel_valid), int'(exp >= 0));
      if (exp >= 0) begin
        chk({req, " warp"}, int'(sel_warp), exp);
        last = exp;
      end
      @(negedge clk);
    end
    ready = '0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    cycles(3);
    chk("R1 mask in reset", int'(allow_mask), 8'hFF);
    @(negedge clk); rst_n = 1; ready = '1;
    #1 chk("R1 first pick", int'(sel_warp), 0);
    chk("R1 first valid", int'(sel_valid), 1);
    ready = '0;
    cycles(20);
    chk("R6 idle admits all", int'(allow_mask), 8'hFF);

    rr_run(300, 8'hFF, "R2 R3 rr all");

    // R8 R10: one hit on warp 3, instr count zero -> 1*16*32/1 = 512
    hit(3);
    cycles(100);
    chk("R8 R10 top only", int'(allow_mask), 8'h08);
    ready = '1; #1;
    chk("R3 pick inside set", int'(sel_warp), 3);
    ready = '0;
    cycles(600);
    chk("R6 decay readmits", int'(allow_mask), 8'hFF);

    // R4: 64 issued, k=2 -> 2*32/64 = 1 -> floor 4
    cfg_k = 8'd2;
    issue(5, 64);
    hit(5);
    cycles(60);
    chk("R4 small quotient floored", int'(allow_mask), 8'hFF);
    // R4: 4 issued, k=16 -> 16*32/4 = 128
    cfg_k = 8'd16;
    issue(6, 4);
    hit(6);
    cycles(50);
    chk("R4 divided score throttles", int'(allow_mask), 8'h40);
    cycles(250);
    chk("R6 back to all", int'(allow_mask), 8'hFF);

    // R5 R7: base 100, 8 active -> cutoff 800; warps 1,4 get 800/2 = 400
    cfg_base = 8'd100; cfg_k = 8'd1;
    issue(1, 2);
    issue(4, 2);
    @(negedge clk); vhit_valid = 1; vhit_warp = 3'd1;
    @(negedge clk); vhit_warp = 3'd4;
    @(negedge clk); vhit_valid = 0;
    cycles(78);
    chk("R5 R7 two admitted", int'(allow_mask), 8'h12);

    cfg_base = 8'd4; cfg_k = 8'd16;
    cycles(500);
    chk("R6 floor again", int'(allow_mask), 8'hFF);
    active = 8'h3F;
    cycles(30);
    chk("R9 inactive excluded", int'(allow_mask), 8'h3F);
    rr_run(150, 8'h3F, "R3 R9 rr subset");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule